// File: doc/BRIEF.md
# Pass-Through Burst Read Responder

This block sits on the local side of a PCI bridge and serves read bursts that the bridge's pass-through channel requests. When the bridge pulls its attention line low, the responder can first fetch the pass-through address by pulsing an address strobe. The bridge drives the address onto the shared data bus while the strobe is low. The responder then keeps one quiet cycle so that the bus can turn around. After that it pushes words from a local valid/ready source into the bridge's read FIFO, one word per completed data phase.

The bridge stores a word only on a clock edge where the write strobe and the ready line are both low. When the local source has no word, the responder inserts a wait state. The bridge signals the end of the burst one transfer early: its burst line rises once the second-to-last word has been stored, and its attention line rises once the last word has been stored. The responder tracks this so that a transfer delayed by its own wait states is still completed. It then releases every strobe and the bus, and can accept a new access on the next clock.

Top module: `ptrd_responder`

## Requirements
- R1: With `FETCH_ADDR`=1, a low `attn_n` seen in idle drives `adr_strobe_n` low for exactly one cycle. `dq_in` is captured on the edge that ends that cycle. In the following cycle `addr_vld` is high and `addr_out` holds the captured value.
- R2: `dq_oe` is low in the cycle where `adr_strobe_n` is low and in the cycle right after it (the turnaround cycle).
- R3: During a data phase, `wr_n` and `rdy_n` are both low, `dq_oe` is high, `sel_n` is low and `reg_adr` equals `FIFO_REG`. While `sel_n` is low, `be_n` mirrors `bridge_be_n`; otherwise `be_n` is all ones and `reg_adr` is zero.
- R4: `src_ready` is high only in a cycle where `src_valid` is high. The word accepted on that edge is driven on `dq_out` as a data phase in the next cycle. Words reach the bridge in the order the source supplies them.
- R5: A wait state is a cycle in which `sel_n` is low but `wr_n` and `rdy_n` are high. In a wait state `dq_oe` is low, and no data phase ever has `dq_oe` low.
- R6: Let a phase complete at an edge. If `attn_n` is low and `burst_n` is low at that edge, another phase is owed. If `attn_n` is low and `burst_n` is high, another phase is owed only when no phase completes at that edge. If `attn_n` is high, nothing is owed. Consequently no data phase occurs while `attn_n` is high, and the number of words stored equals the count the bridge requested.
- R7: Once nothing is owed, `sel_n`, `wr_n` and `rdy_n` return high, `dq_oe` returns low and `be_n` returns to all ones in the next cycle. They stay there while `attn_n` stays high.
- R8: An active-low synchronous `rst_n` returns the block to idle with `adr_strobe_n`, `sel_n`, `wr_n` and `rdy_n` high and `dq_oe`, `addr_vld` and `src_ready` low.
- R9: While `attn_n` is high, `src_valid` has no effect: `src_ready` stays low and no address strobe or data phase starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| attn_n | input | 1 | Bridge attention, low while words are still owed |
| burst_n | input | 1 | Bridge burst, low while two or more words are owed |
| bridge_be_n | input | DATA_W/8 | Bridge byte-valid flags for the next word, active low |
| adr_strobe_n | output | 1 | Address read strobe, active low |
| dq_in | input | DATA_W | Shared data bus, incoming value |
| dq_out | output | DATA_W | Shared data bus, value driven by the responder |
| dq_oe | output | 1 | Output enable for `dq_out` |
| sel_n | output | 1 | Select, active low |
| reg_adr | output | REG_ADR_W | Register address of the bridge's read FIFO |
| be_n | output | DATA_W/8 | Byte enables toward the bridge, active low |
| wr_n | output | 1 | Write strobe, active low |
| rdy_n | output | 1 | Data phase complete, active low |
| src_valid | input | 1 | Local source has a word |
| src_data | input | DATA_W | Local source word |
| src_ready | output | 1 | Local word accepted on this edge |
| addr_out | output | DATA_W | Captured pass-through address |
| addr_vld | output | 1 | One-cycle pulse marking a new `addr_out` |

## Verification
The bench builds the block with its defaults: a 32-bit bus, four byte lanes and address fetch enabled. This exercises the strobe, turnaround and data sequence on every burst. A bus-functional bridge stores words only on edges where both strobes are low. It raises burst one word early and attention on the last word. Because source stalls are random, wait states fall right before the final owed transfer, which exercises the case where the end of the burst is signalled early. Directed bursts of one and two words, a back-to-back burst and a reset in the middle of a burst cover the boundary cases.

// File: rtl/ptrd_pkg.sv
package ptrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_TURN = 2'd2,
        ST_DATA = 2'd3
    } ptrd_state_e;

endpackage

// File: rtl/ptrd_owed.sv
module ptrd_owed (
    input  logic attn_n,
    input  logic burst_n,
    input  logic phase_live,
    output logic owed_next
);

    // Burst low: at least two words remain, so one remains after any completion.
    // Burst high with attention low: exactly one remains.
    always_comb begin
        owed_next = 1'b0;
        if (!attn_n) begin
            owed_next = !burst_n || !phase_live;
        end
    end

endmodule

// File: rtl/ptrd_addr_cap.sv
module ptrd_addr_cap #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] addr_q,
    output logic              addr_vld_q
);

    logic [DATA_W-1:0] addr_d;
    logic              addr_vld_d;

    always_comb begin
        addr_d     = addr_q;
        addr_vld_d = cap_en;
        if (cap_en) begin
            addr_d = dq_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            addr_vld_q <= 1'b0;
        end else begin
            addr_q     <= addr_d;
            addr_vld_q <= addr_vld_d;
        end
    end

endmodule

// File: rtl/ptrd_responder.sv
module ptrd_responder
    import ptrd_pkg::*;
#(
    parameter int                     DATA_W     = 32,
    parameter int                     REG_ADR_W  = 5,
    parameter logic [REG_ADR_W-1:0]   FIFO_REG   = 5'd11,
    parameter bit                     FETCH_ADDR = 1'b1,
    localparam int                    BE_W       = DATA_W / 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 attn_n,
    input  logic                 burst_n,
    input  logic [BE_W-1:0]      bridge_be_n,
    output logic                 adr_strobe_n,
    input  logic [DATA_W-1:0]    dq_in,
    output logic [DATA_W-1:0]    dq_out,
    output logic                 dq_oe,
    output logic                 sel_n,
    output logic [REG_ADR_W-1:0] reg_adr,
    output logic [BE_W-1:0]      be_n,
    output logic                 wr_n,
    output logic                 rdy_n,
    input  logic                 src_valid,
    input  logic [DATA_W-1:0]    src_data,
    output logic                 src_ready,
    output logic [DATA_W-1:0]    addr_out,
    output logic                 addr_vld
);

    typedef struct packed {
        ptrd_state_e       st;
        logic              strobe_n;
        logic              sel_n;
        logic              wr_n;
        logic              oe;
        logic [DATA_W-1:0] dq;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st:       ST_IDLE,
        strobe_n: 1'b1,
        sel_n:    1'b1,
        wr_n:     1'b1,
        oe:       1'b0,
        dq:       '0
    };

    regs_t r_d, r_q;
    logic  take;
    logic  cap_en;
    logic  phase_live;
    logic  owed_next;

    assign phase_live = !r_q.wr_n;

    ptrd_owed u_owed (
        .attn_n     (attn_n),
        .burst_n    (burst_n),
        .phase_live (phase_live),
        .owed_next  (owed_next)
    );

    ptrd_addr_cap #(
        .DATA_W (DATA_W)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_en),
        .dq_in      (dq_in),
        .addr_q     (addr_out),
        .addr_vld_q (addr_vld)
    );

    always_comb begin
        r_d    = r_q;
        take   = 1'b0;
        cap_en = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (!attn_n) begin
                    if (FETCH_ADDR) begin
                        r_d.st       = ST_ADDR;
                        r_d.strobe_n = 1'b0;
                    end else begin
                        r_d.st    = ST_DATA;
                        r_d.sel_n = 1'b0;
                        take      = src_valid;
                    end
                end
            end
            ST_ADDR: begin
                // address sits on dq_in during this cycle; latch at its end
                r_d.strobe_n = 1'b1;
                r_d.st       = ST_TURN;
                cap_en       = 1'b1;
            end
            ST_TURN: begin
                r_d.st    = ST_DATA;
                r_d.sel_n = 1'b0;
                take      = src_valid && !attn_n;
            end
            ST_DATA: begin
                if (owed_next) begin
                    take = src_valid;
                end else begin
                    r_d.st    = ST_IDLE;
                    r_d.sel_n = 1'b1;
                end
            end
            default: r_d = REGS_RST;
        endcase
        r_d.wr_n = !take;
        r_d.oe   = take;
        r_d.dq   = take ? src_data : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign adr_strobe_n = r_q.strobe_n;
    assign sel_n        = r_q.sel_n;
    assign wr_n         = r_q.wr_n;
    assign rdy_n        = r_q.wr_n;
    assign dq_oe        = r_q.oe;
    assign dq_out       = r_q.dq;
    assign src_ready    = take;
    assign reg_adr      = r_q.sel_n ? '0 : FIFO_REG;
    assign be_n         = r_q.sel_n ? '1 : bridge_be_n;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !adr_strobe_n |=> adr_strobe_n);                                   // R1
    AST_ADDR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !adr_strobe_n |=> addr_vld);                                       // R1
    AST_TURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !adr_strobe_n |=> !dq_oe);                                         // R2
    AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !adr_strobe_n |-> !dq_oe);                                         // R2
    AST_PHASE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !sel_n);                                                 // R3
    AST_WORD_HAD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> $past(src_valid));                                       // R4
    AST_NO_WRITE_UNATTN: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !attn_n);                                                // R6
    AST_LAST_OWED: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && burst_n && !attn_n) |=> wr_n);                           // R6
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DATA && attn_n && wr_n) |=> (sel_n && !dq_oe));      // R7
    AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        attn_n |-> !src_ready);                                            // R9

endmodule

// File: tb/tb_ptrd_responder.sv
module tb_ptrd_responder;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;
    localparam int RA_W       = 5;
    localparam int BE_W       = DATA_W / 8;
    localparam logic [RA_W-1:0] FIFO_REG = 5'd11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              attn_n, burst_n;
    logic [BE_W-1:0]   bridge_be_n;
    logic              adr_strobe_n;
    logic [DATA_W-1:0] dq_in, dq_out;
    logic              dq_oe, sel_n, wr_n, rdy_n;
    logic [RA_W-1:0]   reg_adr;
    logic [BE_W-1:0]   be_n;
    logic              src_valid = 1'b0;
    logic [DATA_W-1:0] src_data = '0;
    logic              src_ready;
    logic [DATA_W-1:0] addr_out;
    logic              addr_vld;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int rem = 0;
    int bstored = 0;
    int src_idx = 0;
    int base = 0;
    logic [DATA_W-1:0] cur_addr = '0;
    logic store_pend = 1'b0;
    logic take_pend  = 1'b0;
    logic prev_strobe_low = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptrd_responder #(
        .DATA_W     (DATA_W),
        .REG_ADR_W  (RA_W),
        .FIFO_REG   (FIFO_REG),
        .FETCH_ADDR (1'b1)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .attn_n       (attn_n),
        .burst_n      (burst_n),
        .bridge_be_n  (bridge_be_n),
        .adr_strobe_n (adr_strobe_n),
        .dq_in        (dq_in),
        .dq_out       (dq_out),
        .dq_oe        (dq_oe),
        .sel_n        (sel_n),
        .reg_adr      (reg_adr),
        .be_n         (be_n),
        .wr_n         (wr_n),
        .rdy_n        (rdy_n),
        .src_valid    (src_valid),
        .src_data     (src_data),
        .src_ready    (src_ready),
        .addr_out     (addr_out),
        .addr_vld     (addr_vld)
    );

    function automatic logic [DATA_W-1:0] data_of(int i);
        return 32'h5A00_0000 ^ (32'(i) * 32'h0001_0307);
    endfunction

    function automatic logic [BE_W-1:0] be_of(int k);
        return (k % 3 == 2) ? 4'b0011 : 4'b0000;
    endfunction

    // bridge model
    assign attn_n      = !(rem >= 1);
    assign burst_n     = !(rem >= 2);
    assign bridge_be_n = be_of(bstored);
    assign dq_in       = !adr_strobe_n ? cur_addr : 32'hFFFF_FFFF;

    always @(posedge clk) begin
        if (store_pend) begin
            rem     <= rem - 1;
            bstored <= bstored + 1;
        end
        if (take_pend) src_idx <= src_idx + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic chk_released(input string req);
        chk(wr_n && rdy_n && sel_n && adr_strobe_n, req,
            {28'd0, wr_n, rdy_n, sel_n, adr_strobe_n}, 32'hF);
        chk(!dq_oe && !src_ready, req, {30'd0, dq_oe, src_ready}, 32'h0);
        chk(be_n == '1 && reg_adr == '0, req, {23'd0, be_n, reg_adr}, {23'd0, 4'hF, 5'd0});
    endtask

    task automatic cycle(input int vprob);
        @(negedge clk);
        src_valid = (($urandom % 100) < vprob);
        src_data  = data_of(src_idx);
        #1;
        store_pend = 1'b0;
        take_pend  = 1'b0;
        if (rst_n) begin
            store_pend = !wr_n && !rdy_n;
            take_pend  = src_valid && src_ready;
            if (store_pend) begin
                chk(!attn_n, "R6 write under attention", {31'd0, attn_n}, 32'd0);
                chk(dq_oe && !sel_n && reg_adr == FIFO_REG, "R3 phase signals",
                    {25'd0, dq_oe, sel_n, reg_adr}, {25'd0, 1'b1, 1'b0, FIFO_REG});
                chk(dq_out == data_of(base + bstored), "R4 word order", dq_out,
                    data_of(base + bstored));
                chk(be_n == be_of(bstored), "R3 byte enables", {28'd0, be_n},
                    {28'd0, be_of(bstored)});
            end
            chk(!(src_ready && !src_valid), "R4 ready without valid",
                {31'd0, src_ready}, 32'd0);
            chk(!(wr_n && dq_oe), "R5 bus driven in wait", {31'd0, dq_oe}, 32'd0);
            if (!adr_strobe_n || prev_strobe_low)
                chk(!dq_oe, "R2 turnaround", {31'd0, dq_oe}, 32'd0);
            if (addr_vld)
                chk(addr_out == cur_addr, "R1 address capture", addr_out, cur_addr);
            if (rem == 0)
                chk(!src_ready && adr_strobe_n, "R9 idle ignores source",
                    {30'd0, src_ready, adr_strobe_n}, 32'd1);
            prev_strobe_low = !adr_strobe_n;
        end
    endtask

    task automatic run_burst(input int n, input int vprob, input logic [DATA_W-1:0] a);
        int guard;
        bit saw_addr;
        @(negedge clk);
        rem      <= n;
        bstored  <= 0;
        base      = src_idx;
        cur_addr  = a;
        guard     = 0;
        saw_addr  = 1'b0;
        cycle(vprob);
        while (!(rem == 0 && sel_n && adr_strobe_n) && guard < 2000) begin
            if (addr_vld) saw_addr = 1'b1;
            cycle(vprob);
            guard++;
        end
        chk(saw_addr, "R1 address pulse seen", {31'd0, saw_addr}, 32'd1);
        chk(bstored == n, "R6 word count", 32'(bstored), 32'(n));
        chk_released("R7 release after burst");
        cycle(100);
        chk_released("R7 stays idle");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        repeat (3) cycle(0);
        chk_released("R8 reset state");
        chk(!addr_vld, "R8 reset address flag", {31'd0, addr_vld}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) cycle(100);               // R9 source valid while idle
        run_burst(1, 100, 32'h0000_1000);    // single word, burst line never low
        run_burst(2, 100, 32'h0000_2040);
        run_burst(2, 25,  32'h0000_3080);
        run_burst(8, 100, 32'h0000_40C0);    // back-to-back
        run_burst(5, 10,  32'h0000_5100);    // heavy stalls near the end
        // reset in the middle of a burst (R8)
        @(negedge clk);
        rem     <= 6;
        bstored <= 0;
        base     = src_idx;
        repeat (5) cycle(100);
        @(negedge clk);
        rst_n      = 1'b0;
        store_pend = 1'b0;
        take_pend  = 1'b0;
        rem       <= 0;
        repeat (2) cycle(0);
        chk_released("R8 reset mid burst");
        @(negedge clk);
        rst_n = 1'b1;
        prev_strobe_low = 1'b0;
        cycle(100);
        for (int b = 0; b < 30; b++) begin
            run_burst(1 + int'($urandom % 8), 10 + int'($urandom % 91),
                      32'h0001_0000 + 32'(b * 64));
        end
        finish_run();
    end

endmodule